// File: doc/BRIEF.md
# Reservation Station with Oldest-First Dispatch

This block is a central holding buffer that sits between instruction issue and a single execution unit. Up to two instructions arrive each cycle through two issue ports. Each instruction carries an opcode, a destination tag and two source operands. A source is either a value that is already known or the tag of a result that is still being computed. Sources are read when the instruction is issued. A missing source is held as a tag and filled in later from a result bus, which broadcasts completed tags and their values.

Each cycle the block looks at its entries and finds those whose two sources are both present. It sends the oldest of them to the execution unit through a registered dispatch port and frees its slot. An older entry that is still waiting does not hold back younger entries that are ready. When fewer slots are free than instructions are offered, issue is refused as a whole for that cycle. The execution unit always accepts a dispatched instruction.

Top module: `rs_oldest_first`

## Requirements
- R1: An entry is dispatched only when both of its sources hold values. An entry with a missing source never appears on the dispatch port.
- R2: When several entries are ready, the one issued earliest is dispatched. Of two instructions issued in the same cycle, port 0 counts as older than port 1.
- R3: An older entry that is still waiting for a source does not prevent a younger ready entry from being dispatched.
- R4: An instruction written at clock edge k appears on the dispatch outputs no earlier than edge k+1. At most one instruction is dispatched per cycle.
- R5: A result broadcast (`res_vld`=1) whose tag equals a waiting source's tag (the low TAG_W bits of that source) fills that source with `res_data`. The entry becomes eligible in the following cycle. A broadcast with any other tag changes nothing.
- R6: A broadcast that arrives in the same cycle as an issue is forwarded to the issuing instruction's matching sources. Such an instruction does not wait for a second broadcast.
- R7: `iss_stall` is 1 exactly when the number of asserted `iss_vld` bits is greater than the number of free entries. A stall holds off all instructions offered that cycle, and none of them is ever stored.
- R8: Both issue ports can store an instruction in the same cycle. Each port delivers its opcode, destination and source values unchanged to the dispatch port.
- R9: Synchronous active-high reset empties the buffer and clears `disp_vld`. Entries issued before reset are never dispatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_vld | input | 2 | Instruction offered on issue port 0 / 1 |
| iss_op | input | 2x OP_W | Opcode per issue port |
| iss_dst | input | 2x TAG_W | Destination tag per issue port |
| iss_a_rdy | input | 2 | Source A holds a value (1) or a tag in its low TAG_W bits (0) |
| iss_a | input | 2x DATA_W | Source A value or pending tag |
| iss_b_rdy | input | 2 | Source B holds a value (1) or a tag (0) |
| iss_b | input | 2x DATA_W | Source B value or pending tag |
| iss_stall | output | 1 | Offered instructions refused this cycle |
| res_vld | input | 1 | Result broadcast valid |
| res_tag | input | TAG_W | Tag of the completed result |
| res_data | input | DATA_W | Value of the completed result |
| disp_vld | output | 1 | Instruction on the dispatch port |
| disp_op | output | OP_W | Dispatched opcode |
| disp_dst | output | TAG_W | Dispatched destination tag |
| disp_a | output | DATA_W | Dispatched source A value |
| disp_b | output | DATA_W | Dispatched source B value |

## Verification
The bench parks an older entry on a missing source behind two younger ready ones. A design that dispatched in order would freeze, and one that ignored age would send the younger pair out in the wrong order. It also sends a broadcast with a non-matching tag first, which catches a wakeup that does not compare the tag. It then issues an instruction in the very cycle its producer broadcasts, where a missing forward path leaves the entry stuck for good. Last, it offers two instructions with only one slot free and then releases every waiting entry at once. If the design took part of a refused pair, an extra dispatch would show up, and if it aged entries wrongly, the three released entries would drain out of order.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Number of issue ports feeding the buffer in one cycle.
  localparam int ISS_PORTS = 2;
endpackage

// File: rtl/rs_wake.sv
// One operand slot: captures a broadcast result whose tag matches a
// waiting operand. Used both on the issue path and on stored entries.
module rs_wake #(
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic              have_i,
  input  logic [DATA_W-1:0] val_i,
  input  logic              bus_vld,
  input  logic [TAG_W-1:0]  bus_tag,
  input  logic [DATA_W-1:0] bus_data,
  output logic              have_o,
  output logic [DATA_W-1:0] val_o
);
  logic hit;
  assign hit    = !have_i && bus_vld && (val_i[TAG_W-1:0] == bus_tag);
  assign have_o = have_i | hit;
  assign val_o  = hit ? bus_data : val_i;
endmodule

// File: rtl/rs_alloc.sv
// Finds the two lowest-numbered free slots.
module rs_alloc #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0] busy,
  output logic             f0_vld,
  output logic [IDX_W-1:0] f0_idx,
  output logic             f1_vld,
  output logic [IDX_W-1:0] f1_idx
);
  always_comb begin
    f0_vld = 1'b0;
    f1_vld = 1'b0;
    f0_idx = '0;
    f1_idx = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (!busy[i]) begin
        if (!f0_vld) begin
          f0_vld = 1'b1;
          f0_idx = IDX_W'(i);
        end else if (!f1_vld) begin
          f1_vld = 1'b1;
          f1_idx = IDX_W'(i);
        end
      end
    end
  end
endmodule

// File: rtl/rs_pick.sv
// Chooses the ready entry with the smallest age rank (oldest).
module rs_pick #(
  parameter int DEPTH = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic [DEPTH-1:0]            ready,
  input  logic [DEPTH-1:0][IDX_W-1:0] rank,
  output logic                        found,
  output logic [IDX_W-1:0]            idx
);
  logic [IDX_W-1:0] best;
  always_comb begin
    found = 1'b0;
    idx   = '0;
    best  = '1;
    for (int i = 0; i < DEPTH; i++) begin
      if (ready[i] && (!found || rank[i] < best)) begin
        found = 1'b1;
        idx   = IDX_W'(i);
        best  = rank[i];
      end
    end
  end
endmodule

// File: rtl/rs_oldest_first.sv
module rs_oldest_first
  import rs_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int OP_W   = 4,
  parameter int TAG_W  = 4,
  parameter int DATA_W = 16
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic [ISS_PORTS-1:0]                 iss_vld,
  input  logic [ISS_PORTS-1:0][OP_W-1:0]       iss_op,
  input  logic [ISS_PORTS-1:0][TAG_W-1:0]      iss_dst,
  input  logic [ISS_PORTS-1:0]                 iss_a_rdy,
  input  logic [ISS_PORTS-1:0][DATA_W-1:0]     iss_a,
  input  logic [ISS_PORTS-1:0]                 iss_b_rdy,
  input  logic [ISS_PORTS-1:0][DATA_W-1:0]     iss_b,
  output logic                                 iss_stall,
  input  logic                                 res_vld,
  input  logic [TAG_W-1:0]                     res_tag,
  input  logic [DATA_W-1:0]                    res_data,
  output logic                                 disp_vld,
  output logic [OP_W-1:0]                      disp_op,
  output logic [TAG_W-1:0]                     disp_dst,
  output logic [DATA_W-1:0]                    disp_a,
  output logic [DATA_W-1:0]                    disp_b
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam int OCC_W = $clog2(DEPTH + 1);

  // Entry storage
  logic [DEPTH-1:0]            vld_q;
  logic [OP_W-1:0]             op_q  [DEPTH];
  logic [TAG_W-1:0]            dst_q [DEPTH];
  logic [DEPTH-1:0]            ar_q, br_q;
  logic [DATA_W-1:0]           a_q   [DEPTH];
  logic [DATA_W-1:0]           b_q   [DEPTH];
  logic [DEPTH-1:0][IDX_W-1:0] rank_q;

  // Wakeup of stored operands
  logic [DEPTH-1:0]  ar_w, br_w;
  logic [DATA_W-1:0] a_w [DEPTH];
  logic [DATA_W-1:0] b_w [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    rs_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wa (
      .have_i(ar_q[i]), .val_i(a_q[i]), .bus_vld(res_vld), .bus_tag(res_tag),
      .bus_data(res_data), .have_o(ar_w[i]), .val_o(a_w[i]));
    rs_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_wb (
      .have_i(br_q[i]), .val_i(b_q[i]), .bus_vld(res_vld), .bus_tag(res_tag),
      .bus_data(res_data), .have_o(br_w[i]), .val_o(b_w[i]));
  end

  // Forwarding of a same-cycle broadcast into the issuing instructions
  logic [ISS_PORTS-1:0]  ia_rdy, ib_rdy;
  logic [DATA_W-1:0]     ia_val [ISS_PORTS];
  logic [DATA_W-1:0]     ib_val [ISS_PORTS];

  for (genvar p = 0; p < ISS_PORTS; p++) begin : g_iss
    rs_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_fa (
      .have_i(iss_a_rdy[p]), .val_i(iss_a[p]), .bus_vld(res_vld), .bus_tag(res_tag),
      .bus_data(res_data), .have_o(ia_rdy[p]), .val_o(ia_val[p]));
    rs_wake #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_fb (
      .have_i(iss_b_rdy[p]), .val_i(iss_b[p]), .bus_vld(res_vld), .bus_tag(res_tag),
      .bus_data(res_data), .have_o(ib_rdy[p]), .val_o(ib_val[p]));
  end

  // Occupancy and issue admission
  logic [OCC_W-1:0] occ;
  always_comb begin
    occ = '0;
    for (int i = 0; i < DEPTH; i++) occ = occ + OCC_W'(vld_q[i]);
  end

  logic [OCC_W-1:0]     n_offer;
  logic [ISS_PORTS-1:0] acc;
  assign n_offer   = OCC_W'(iss_vld[0]) + OCC_W'(iss_vld[1]);
  assign iss_stall = n_offer > (OCC_W'(DEPTH) - occ);
  assign acc       = iss_stall ? '0 : iss_vld;

  // Oldest-ready selection
  logic [DEPTH-1:0] ready;
  logic             sel_vld;
  logic [IDX_W-1:0] sel_idx;
  assign ready = vld_q & ar_q & br_q;

  rs_pick #(.DEPTH(DEPTH)) u_pick (
    .ready(ready), .rank(rank_q), .found(sel_vld), .idx(sel_idx));

  // Slot allocation
  logic             f0_vld, f1_vld;
  logic [IDX_W-1:0] f0_idx, f1_idx;
  rs_alloc #(.DEPTH(DEPTH)) u_alloc (
    .busy(vld_q), .f0_vld(f0_vld), .f0_idx(f0_idx), .f1_vld(f1_vld), .f1_idx(f1_idx));

  logic [IDX_W-1:0] slot [ISS_PORTS];
  logic [IDX_W-1:0] new_rank [ISS_PORTS];
  logic [OCC_W-1:0] base;
  assign base        = occ - OCC_W'(sel_vld);
  assign slot[0]     = f0_idx;
  assign slot[1]     = acc[0] ? f1_idx : f0_idx;
  assign new_rank[0] = IDX_W'(base);
  assign new_rank[1] = IDX_W'(base + OCC_W'(acc[0]));

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q    <= '0;
      disp_vld <= 1'b0;
    end else begin
      for (int i = 0; i < DEPTH; i++) begin
        ar_q[i] <= ar_w[i];
        a_q[i]  <= a_w[i];
        br_q[i] <= br_w[i];
        b_q[i]  <= b_w[i];
        if (sel_vld && vld_q[i] && rank_q[i] > rank_q[sel_idx])
          rank_q[i] <= rank_q[i] - 1'b1;
      end
      disp_vld <= sel_vld;
      if (sel_vld) begin
        vld_q[sel_idx] <= 1'b0;
        disp_op        <= op_q[sel_idx];
        disp_dst       <= dst_q[sel_idx];
        disp_a         <= a_q[sel_idx];
        disp_b         <= b_q[sel_idx];
      end
      for (int p = 0; p < ISS_PORTS; p++) begin
        if (acc[p]) begin
          vld_q[slot[p]]  <= 1'b1;
          op_q[slot[p]]   <= iss_op[p];
          dst_q[slot[p]]  <= iss_dst[p];
          ar_q[slot[p]]   <= ia_rdy[p];
          a_q[slot[p]]    <= ia_val[p];
          br_q[slot[p]]   <= ib_rdy[p];
          b_q[slot[p]]    <= ib_val[p];
          rank_q[slot[p]] <= new_rank[p];
        end
      end
    end
  end

  logic unused_ok;
  assign unused_ok = f0_vld ^ f1_vld;
endmodule

// File: rtl/rs_oldest_first_chk.sv
module rs_oldest_first_chk #(
  parameter int DEPTH = 4,
  parameter int OCC_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic [1:0]       iss_vld,
  input logic             iss_stall,
  input logic             disp_vld,
  input logic [OCC_W-1:0] occ
);
  // R4: an empty buffer has nothing to send next cycle
  assert_empty_quiet_R4: assert property (@(posedge clk) disable iff (rst)
    occ == '0 |=> !disp_vld);

  // R1: a dispatch needs an entry held the cycle before
  assert_disp_needs_entry_R1: assert property (@(posedge clk) disable iff (rst)
    disp_vld |-> $past(occ) != '0);

  // R7: a stalled cycle adds no entry
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
    iss_stall |=> occ <= $past(occ));

  // R7: a full buffer refuses any offer
  assert_full_refuses_R7: assert property (@(posedge clk) disable iff (rst)
    (occ == OCC_W'(DEPTH) && iss_vld != 2'b00) |-> iss_stall);

  // R4: at most one entry leaves per cycle
  assert_single_leave_R4: assert property (@(posedge clk) disable iff (rst)
    ({1'b0, occ} + 1'b1) >= {1'b0, $past(occ)});

  // R4: with no issue, occupancy never grows
  assert_idle_no_growth_R4: assert property (@(posedge clk) disable iff (rst)
    iss_vld == 2'b00 |=> occ <= $past(occ));
endmodule

bind rs_oldest_first rs_oldest_first_chk #(.DEPTH(DEPTH), .OCC_W(OCC_W)) u_chk (
  .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_stall(iss_stall),
  .disp_vld(disp_vld), .occ(occ));

// File: tb/rs_oldest_first_bench.sv
module rs_oldest_first_bench;
  localparam int CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst;
  logic [1:0]       iss_vld;
  logic [1:0][3:0]  iss_op, iss_dst;
  logic [1:0]       iss_a_rdy, iss_b_rdy;
  logic [1:0][15:0] iss_a, iss_b;
  logic             iss_stall;
  logic             res_vld;
  logic [3:0]       res_tag;
  logic [15:0]      res_data;
  logic             disp_vld;
  logic [3:0]       disp_op, disp_dst;
  logic [15:0]      disp_a, disp_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_oldest_first u_rs_oldest_first (
    .clk(clk), .rst(rst), .iss_vld(iss_vld), .iss_op(iss_op), .iss_dst(iss_dst),
    .iss_a_rdy(iss_a_rdy), .iss_a(iss_a), .iss_b_rdy(iss_b_rdy), .iss_b(iss_b),
    .iss_stall(iss_stall), .res_vld(res_vld), .res_tag(res_tag), .res_data(res_data),
    .disp_vld(disp_vld), .disp_op(disp_op), .disp_dst(disp_dst),
    .disp_a(disp_a), .disp_b(disp_b));

  // {op, dst, a, b}
  localparam logic [39:0] VECS [8] = '{
    40'h31_00AA_0055, 40'h72_1234_5678, 40'hF3_FFFF_0000, 40'h04_0001_8000,
    40'h95_A5A5_5A5A, 40'h56_7FFF_0F0F, 40'hC7_0000_FFFF, 40'h18_C0DE_D00D};

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic clear_in();
    iss_vld = '0; iss_op = '0; iss_dst = '0; iss_a_rdy = '0; iss_b_rdy = '0;
    iss_a = '0; iss_b = '0; res_vld = 0; res_tag = '0; res_data = '0;
  endtask

  task automatic put(input int p, input logic [3:0] op, input logic [3:0] dst,
                     input logic ar, input logic [15:0] a,
                     input logic br, input logic [15:0] b);
    iss_vld[p] = 1'b1; iss_op[p] = op; iss_dst[p] = dst;
    iss_a_rdy[p] = ar; iss_a[p] = a; iss_b_rdy[p] = br; iss_b[p] = b;
  endtask

  task automatic bcast(input logic [3:0] tag, input logic [15:0] data);
    res_vld = 1'b1; res_tag = tag; res_data = data;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    clear_in();
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;

    // R9: reset state; empty buffer admits two
    check("R9 disp_vld after reset", 32'(disp_vld), 32'd0);
    put(0, 4'h1, 4'h1, 1, 16'h1, 1, 16'h1);
    put(1, 4'h1, 4'h2, 1, 16'h1, 1, 16'h1);
    #1 check("R7 no stall when empty", 32'(iss_stall), 32'd0);
    clear_in();

    // R8/R4: vector table, ports alternate
    for (int k = 0; k < 8; k++) begin
      put(k % 2, VECS[k][39:36], VECS[k][35:32], 1, VECS[k][31:16], 1, VECS[k][15:0]);
      @(negedge clk);
      clear_in();
      check("R4 not before next edge", 32'(disp_vld), 32'd0);
      @(negedge clk);
      check("R8 disp_vld", 32'(disp_vld), 32'd1);
      check("R8 fields", {disp_op, disp_dst, disp_a[7:0], disp_b[7:0]},
            {VECS[k][39:32], VECS[k][23:16], VECS[k][7:0]});
      check("R8 src A", 32'(disp_a), 32'(VECS[k][31:16]));
      check("R8 src B", 32'(disp_b), 32'(VECS[k][15:0]));
    end
    @(negedge clk);

    // R3/R2/R1/R5: older entry waits on tag 5, younger pair ready
    put(0, 4'h2, 4'hA, 0, 16'h0005, 1, 16'h0002);
    @(negedge clk);
    clear_in();
    put(0, 4'h3, 4'hB, 1, 16'h0011, 1, 16'h0022);
    put(1, 4'h4, 4'hC, 1, 16'h0033, 1, 16'h0044);
    @(negedge clk);
    clear_in();
    check("R1 waiting entry held", 32'(disp_vld), 32'd0);
    @(negedge clk);
    check("R3 younger passes blocked older", 32'(disp_vld), 32'd1);
    check("R2 port0 older than port1", 32'(disp_dst), 32'hB);
    bcast(4'h6, 16'hDEAD);
    @(negedge clk);
    clear_in();
    check("R2 second of pair", 32'(disp_dst), 32'hC);
    @(negedge clk);
    check("R5 wrong tag does not wake", 32'(disp_vld), 32'd0);
    bcast(4'h5, 16'h1234);
    @(negedge clk);
    clear_in();
    check("R5 wakes next cycle not same", 32'(disp_vld), 32'd0);
    @(negedge clk);
    check("R5 woken entry dispatched", 32'(disp_dst), 32'hA);
    check("R5 captured value", 32'(disp_a), 32'h1234);
    check("R5 other source kept", 32'(disp_b), 32'h0002);
    @(negedge clk);

    // R6: broadcast in the issue cycle
    put(1, 4'h5, 4'hD, 0, 16'h0007, 0, 16'h0007);
    bcast(4'h7, 16'hBEEF);
    @(negedge clk);
    clear_in();
    @(negedge clk);
    check("R6 forwarded entry dispatched", 32'(disp_vld), 32'd1);
    check("R6 forwarded A", 32'(disp_a), 32'hBEEF);
    check("R6 forwarded B", 32'(disp_b), 32'hBEEF);
    @(negedge clk);

    // R7: three waiting entries, one slot free
    put(0, 4'h6, 4'h1, 0, 16'h0009, 1, 16'h0);
    put(1, 4'h6, 4'h2, 0, 16'h0009, 1, 16'h0);
    @(negedge clk);
    clear_in();
    put(0, 4'h6, 4'h3, 0, 16'h0009, 1, 16'h0);
    @(negedge clk);
    clear_in();
    put(0, 4'h6, 4'hE, 1, 16'h0, 1, 16'h0);
    #1 check("R7 one offered one free", 32'(iss_stall), 32'd0);
    put(1, 4'h6, 4'hF, 1, 16'h0, 1, 16'h0);
    #1 check("R7 two offered one free", 32'(iss_stall), 32'd1);
    @(negedge clk);
    clear_in();
    bcast(4'h9, 16'h0055);
    @(negedge clk);
    clear_in();
    @(negedge clk);
    check("R2 oldest of three", 32'(disp_dst), 32'h1);
    check("R5 shared wake value", 32'(disp_a), 32'h0055);
    @(negedge clk);
    check("R2 second of three", 32'(disp_dst), 32'h2);
    @(negedge clk);
    check("R2 third of three", 32'(disp_dst), 32'h3);
    @(negedge clk);
    check("R7 refused pair never stored", 32'(disp_vld), 32'd0);

    // R9: entry issued before reset is dropped
    put(0, 4'h8, 4'h9, 1, 16'h1, 1, 16'h2);
    @(negedge clk);
    clear_in();
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    check("R9 disp cleared", 32'(disp_vld), 32'd0);
    @(negedge clk);
    check("R9 entry dropped", 32'(disp_vld), 32'd0);
    @(negedge clk);
    check("R9 still empty", 32'(disp_vld), 32'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule